// File: doc/BRIEF.md
# Multi-Counter Performance Monitor Unit

This block counts hardware activity for profiling. It has one free-running cycle counter and four event counters, each 32 bits wide. Every clock cycle, each event counter looks at one of the chip's event strobes. It picks that strobe with an 8-bit code held in a shared select register. The cycle counter can be slowed so that it advances once every 64 enabled cycles. This lets it cover long intervals without wrapping.

Software preloads a counter with the two's complement of a sampling period. It then enables the counter's interrupt and turns counting on. When the counter wraps, its overflow flag is set and the interrupt line rises. The handler reads the flag register and writes the same value back to clear exactly the flags it saw. It then reloads the counter and continues.

Register map (word addresses):

| Address | Register |
|---|---|
| 0 | control |
| 1 | event select |
| 2 | interrupt enable |
| 3 | overflow flags |
| 4 | cycle counter |
| 5 to 8 | event counters 0 to 3 |

Any other address reads as zero.

Top module: `perf_monitor_unit`

## Requirements
- R1: After synchronous reset, every register and counter reads zero and `pmu_irq` is low.
- R2: Control bit 0 is the run enable and control bit 3 selects the divide-by-64 cycle count. A read of the control register returns only these two bits; all other bits read as zero.
- R3: While the run enable is 0, no counter advances.
- R4: The event-select register holds event counter k's code in bits 8k+7:8k. While running, counter k adds one in every cycle in which `event_strobe[code]` is high.
- R5: A code equal to or above the number of strobe inputs, 0xFF included, never advances its counter.
- R6: While running, the cycle counter adds one per cycle. With bit 3 set, it adds one only in the cycle where the internal modulo-64 prescaler is at 63. That prescaler advances on every running cycle.
- R7: Each counter is written and read as a full 32-bit word. A write to a counter wins over an increment in the same cycle.
- R8: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag whatever its enable. Flag bit 0 belongs to the cycle counter and bits 1 to 4 to event counters 0 to 3. A set flag stays set until cleared, even if the counter wraps again.
- R9: The interrupt-enable register uses the same bit order as the flags. `pmu_irq` equals the OR of flag AND enable over all five bits, and it changes on the same edge as the flags and enables.
- R10: Writing 1 to a flag bit clears it and writing 0 leaves it. A wrap in the same cycle as a clear leaves the flag set.
- R11: Writing control bit 1 clears all event counters, and writing bit 2 clears the cycle counter and its prescaler, both at that edge. These two bits always read back as zero.
- R12: Read data is registered. `reg_rdata` shows the addressed register one cycle after `reg_re`, using the value from before that edge, and is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| event_strobe | input | 32 | One strobe per hardware event code |
| pmu_irq | output | 1 | Overflow interrupt |

## Verification
Several properties are checked on every cycle:
- the interrupt line always agrees with the held flags and enables;
- the cycle counter holds still while counting is off;
- flags never drop without a write to the flag register;
- idle read data is zero;
- control reads never show reserved or reset bits.

Other behaviour depends on exact counts across many cycles, and only the bench's scenarios, compared against its behavioural model, can show it. This covers code-driven strobe selection, out-of-range codes, the 64-cycle prescale phase, write-over-increment priority, wrap detection at 0xFFFFFFFF, and set-over-clear on a simultaneous wrap.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_ESEL = 1;
  localparam int unsigned A_IEN  = 2;
  localparam int unsigned A_FLAG = 3;
  localparam int unsigned A_CYC  = 4;

  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_EVRST = 1;
  localparam int unsigned B_CYRST = 2;
  localparam int unsigned B_DIV   = 3;
endpackage

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrap
);
  logic [W-1:0] val_q;

  assign value = val_q;
  assign wrap  = inc && !load && !clr && (&val_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else if (load) begin
      val_q <= load_val;
    end else if (clr) begin
      val_q <= '0;
    end else if (inc) begin
      val_q <= val_q + 1'b1;
    end
  end
endmodule

// File: rtl/pmu_ctrl_regs.sv
module pmu_ctrl_regs
  import pmu_pkg::*;
#(
  parameter int DW      = 32,
  parameter int ADDR_W  = 4,
  parameter int NUM_CTR = 5,
  parameter int SEL_BITS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DW-1:0]       wdata,
  input  logic [NUM_CTR-1:0]  ovf,
  output logic                run,
  output logic                div64,
  output logic                evrst,
  output logic                cyrst,
  output logic [SEL_BITS-1:0] esel,
  output logic [NUM_CTR-1:0]  ien,
  output logic [NUM_CTR-1:0]  flags,
  output logic                irq
);
  logic                wr_ctrl, wr_esel, wr_ien, wr_flag;
  logic [NUM_CTR-1:0]  flags_d, ien_d, clr_mask;
  logic                run_q, div_q, irq_q;
  logic [SEL_BITS-1:0] esel_q;
  logic [NUM_CTR-1:0]  ien_q, flags_q;

  assign wr_ctrl = we && (addr == ADDR_W'(A_CTRL));
  assign wr_esel = we && (addr == ADDR_W'(A_ESEL));
  assign wr_ien  = we && (addr == ADDR_W'(A_IEN));
  assign wr_flag = we && (addr == ADDR_W'(A_FLAG));

  assign evrst = wr_ctrl && wdata[B_EVRST];
  assign cyrst = wr_ctrl && wdata[B_CYRST];

  always_comb begin
    clr_mask = wr_flag ? wdata[NUM_CTR-1:0] : '0;
    flags_d  = (flags_q & ~clr_mask) | ovf;
    ien_d    = wr_ien ? wdata[NUM_CTR-1:0] : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      div_q   <= 1'b0;
      esel_q  <= '0;
      ien_q   <= '0;
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q <= wdata[B_RUN];
        div_q <= wdata[B_DIV];
      end
      if (wr_esel) begin
        esel_q <= wdata[SEL_BITS-1:0];
      end
      ien_q   <= ien_d;
      flags_q <= flags_d;
      irq_q   <= |(flags_d & ien_d);
    end
  end

  assign run   = run_q;
  assign div64 = div_q;
  assign esel  = esel_q;
  assign ien   = ien_q;
  assign flags = flags_q;
  assign irq   = irq_q;
endmodule

// File: rtl/perf_monitor_unit.sv
module perf_monitor_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int NUM_EVT    = 4,
  parameter int SEL_W      = 8,
  parameter int NUM_EVENTS = 32,
  parameter int PRESCALE   = 64,
  parameter int ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [CNT_W-1:0]      reg_wdata,
  input  logic                  reg_re,
  output logic [CNT_W-1:0]      reg_rdata,
  input  logic [NUM_EVENTS-1:0] event_strobe,
  output logic                  pmu_irq
);
  localparam int NUM_CTR  = NUM_EVT + 1;
  localparam int SEL_BITS = NUM_EVT * SEL_W;
  localparam int EIW      = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;

  logic                run, div64, evrst, cyrst, pre_tick, cyc_inc;
  logic [SEL_BITS-1:0] esel;
  logic [NUM_CTR-1:0]  ien_q, flags_q, ovf, ctr_inc, ctr_clr, ctr_load;
  logic [CNT_W-1:0]    cnt_val [NUM_CTR];
  logic [CNT_W-1:0]    cyc_val;
  logic [CNT_W-1:0]    rd_val, rdata_q;

  pmu_ctrl_regs #(
    .DW(CNT_W), .ADDR_W(ADDR_W), .NUM_CTR(NUM_CTR), .SEL_BITS(SEL_BITS)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ovf(ovf), .run(run), .div64(div64), .evrst(evrst), .cyrst(cyrst),
    .esel(esel), .ien(ien_q), .flags(flags_q), .irq(pmu_irq)
  );

  pmu_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .run(run), .clr(cyrst), .tick(pre_tick)
  );

  assign cyc_inc = run && (!div64 || pre_tick);

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      if (i == 0) begin : g_cyc
        assign ctr_inc[i] = cyc_inc;
        assign ctr_clr[i] = cyrst;
      end else begin : g_evt
        logic [SEL_W-1:0] code;
        assign code       = esel[(i-1)*SEL_W +: SEL_W];
        assign ctr_inc[i] = run && (32'(code) < NUM_EVENTS) && event_strobe[code[EIW-1:0]];
        assign ctr_clr[i] = evrst;
      end
      assign ctr_load[i] = reg_we && (reg_addr == ADDR_W'(A_CYC + i));

      pmu_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(ctr_load[i]), .load_val(reg_wdata),
        .clr(ctr_clr[i]), .inc(ctr_inc[i]), .value(cnt_val[i]), .wrap(ovf[i])
      );
    end
  endgenerate

  assign cyc_val = cnt_val[0];

  always_comb begin
    rd_val = '0;
    if (reg_addr == ADDR_W'(A_CTRL)) begin
      rd_val = CNT_W'({div64, 2'b00, run});
    end else if (reg_addr == ADDR_W'(A_ESEL)) begin
      rd_val = CNT_W'(esel);
    end else if (reg_addr == ADDR_W'(A_IEN)) begin
      rd_val = CNT_W'(ien_q);
    end else if (reg_addr == ADDR_W'(A_FLAG)) begin
      rd_val = CNT_W'(flags_q);
    end else begin
      for (int i = 0; i < NUM_CTR; i++) begin
        if (reg_addr == ADDR_W'(A_CYC + i)) rd_val = cnt_val[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= reg_re ? rd_val : '0;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int DW      = 32,
  parameter int NUM_CTR = 5,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_we,
  input logic               reg_re,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DW-1:0]      reg_rdata,
  input logic               pmu_irq,
  input logic [NUM_CTR-1:0] flags,
  input logic [NUM_CTR-1:0] ien,
  input logic               run,
  input logic [DW-1:0]      cyc_cnt
);
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    pmu_irq == |(flags & ien)); // R9

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !reg_we) |=> $stable(cyc_cnt)); // R3

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == ADDR_W'(3)) |=> ((flags & $past(flags)) == $past(flags))); // R8

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !reg_re |=> (reg_rdata == '0)); // R12

  AST_CTRL_RSV: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_addr == ADDR_W'(0)) |=> (reg_rdata[DW-1:4] == '0 && reg_rdata[2:1] == 2'b00)); // R2
endmodule

bind perf_monitor_unit pmu_checker #(
  .DW(CNT_W), .NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .pmu_irq(pmu_irq), .flags(flags_q), .ien(ien_q),
  .run(run), .cyc_cnt(cyc_val)
);

// File: tb/sim_perf_monitor_unit.sv
`timescale 1ns/1ps
module sim_perf_monitor_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic [31:0] ev = '0;
  logic        pmu_irq;

  always #10 clk = ~clk;

  perf_monitor_unit u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .event_strobe(ev), .pmu_irq(pmu_irq)
  );

  // behavioural reference
  logic [31:0] m_cnt [5];
  logic [7:0]  m_sel [4];
  logic [4:0]  m_flag, m_ien, m_ov;
  logic        m_en, m_div, m_irq, m_tick, m_inc;
  int          m_pre;
  logic [31:0] m_rdata, m_rv;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 5; i++) m_cnt[i] = '0;
      for (int i = 0; i < 4; i++) m_sel[i] = '0;
      m_flag = '0; m_ien = '0; m_en = 0; m_div = 0; m_pre = 0;
      m_irq = 0; m_rdata = '0;
    end else begin
      m_rv = '0;
      if (reg_re) begin
        if (reg_addr == 0) m_rv = {28'b0, m_div, 2'b00, m_en};
        else if (reg_addr == 1) m_rv = {m_sel[3], m_sel[2], m_sel[1], m_sel[0]};
        else if (reg_addr == 2) m_rv = {27'b0, m_ien};
        else if (reg_addr == 3) m_rv = {27'b0, m_flag};
        else if (reg_addr >= 4 && reg_addr <= 8) m_rv = m_cnt[reg_addr - 4];
      end
      m_tick = m_en && (!m_div || m_pre == 63);
      m_ov = '0;
      for (int i = 0; i < 5; i++) begin
        if (i == 0) m_inc = m_tick;
        else m_inc = m_en && (m_sel[i-1] < 32) && ev[m_sel[i-1][4:0]];
        if (reg_we && reg_addr == 4 + i) m_cnt[i] = reg_wdata;
        else if (reg_we && reg_addr == 0 && reg_wdata[(i == 0) ? 2 : 1]) m_cnt[i] = '0;
        else if (m_inc) begin
          if (m_cnt[i] == 32'hFFFF_FFFF) m_ov[i] = 1'b1;
          m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (reg_we && reg_addr == 0 && reg_wdata[2]) m_pre = 0;
      else if (m_en) m_pre = (m_pre == 63) ? 0 : m_pre + 1;
      m_flag = (m_flag & ~((reg_we && reg_addr == 3) ? reg_wdata[4:0] : 5'b0)) | m_ov;
      if (reg_we && reg_addr == 0) begin m_en = reg_wdata[0]; m_div = reg_wdata[3]; end
      if (reg_we && reg_addr == 1) begin
        for (int k = 0; k < 4; k++) m_sel[k] = reg_wdata[8*k +: 8];
      end
      if (reg_we && reg_addr == 2) m_ien = reg_wdata[4:0];
      m_irq = |(m_flag & m_ien);
      m_rdata = m_rv;
    end
  end

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  bit    done = 0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (reg_rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s rdata got %h exp %h at %0t", cur_req, reg_rdata, m_rdata, $time);
      end
      checks++;
      if (pmu_irq !== m_irq) begin
        fails++;
        $display("FAIL R9 irq got %b exp %b at %0t", pmu_irq, m_irq, $time);
      end
    end
  end

  task automatic op(input bit we, input bit re, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = we; reg_re = re; reg_addr = a; reg_wdata = d;
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d); op(1, 0, a, d); endtask
  task automatic rd(input logic [3:0] a); op(0, 1, a, '0); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, '0, '0);
  endtask
  task automatic rd_all();
    for (int a = 0; a < 10; a++) rd(4'(a));
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: run did not complete (exp completion)");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    cur_req = "R1";  rd_all();
    cur_req = "R2";  wr(0, 32'hFFFF_FFF9); rd(0); wr(0, 32'h0); rd(0);
    cur_req = "R4";  wr(1, 32'h0706_0500); rd(1);
    wr(5, 32'd10); wr(6, 32'd20); wr(7, 32'd0); wr(8, 32'd5);
    wr(0, 32'h1);
    for (int i = 0; i < 50; i++) begin ev = $urandom; idle(1); end
    rd_all();
    cur_req = "R5";  wr(1, 32'hFF40_20FF); ev = 32'hFFFF_FFFF; idle(20); rd_all();
    cur_req = "R3";  wr(1, 32'h0302_0100); wr(0, 32'h0); idle(20); rd_all();
    cur_req = "R6";  wr(0, 32'h4); wr(0, 32'h1); idle(10); rd(4);
    wr(0, 32'h9); idle(200); rd(4); wr(0, 32'h1);
    cur_req = "R7";  wr(6, 32'hDEAD_BEEF); rd(6); wr(4, 32'h1234_5678); rd(4);
    cur_req = "R8";  wr(2, 32'h0); wr(5, 32'hFFFF_FFFD); idle(5); rd(3); rd(5);
    wr(5, 32'hFFFF_FFFE); idle(4); rd(3);
    cur_req = "R9";  wr(2, 32'h02); idle(2); rd(2); wr(2, 32'h1F); idle(2);
    cur_req = "R10"; rd(3); wr(3, 32'h02); rd(3); wr(3, 32'h0); idle(2);
    wr(4, 32'hFFFF_FFFE);
    for (int i = 0; i < 6; i++) wr(3, 32'h1);
    rd(3);
    cur_req = "R11"; wr(0, 32'h7); rd_all(); wr(0, 32'h3); idle(3); rd_all();
    cur_req = "R12";
    for (int i = 0; i < 3000; i++) begin
      ev = $urandom;
      case ($urandom % 4)
        0: wr(4'($urandom % 10), ($urandom % 3 == 0) ? (32'hFFFF_FFF0 | 32'($urandom % 16)) : $urandom);
        1: rd(4'($urandom % 10));
        2: op(1, 1, 4'($urandom % 10), $urandom & 32'h1F1F_1F1F);
        default: idle(1);
      endcase
      if (i % 500 == 0) wr(0, 32'h1);
    end
    idle(2);
    finish_run();
  end
endmodule